// File: doc/BRIEF.md
# Per-Lane Half-Cycle Input Skew Aligner

This block removes differences in arrival time between several high-rate serial input lanes. These differences come from backplane paths of unequal length. Every lane is sampled on both the rising and the falling edge of the master clock. The samples enter a short tap line of half-clock-period steps. A per-lane offset code picks which tap is passed on, so each lane can be moved by up to four master clock periods in half-period steps. The same frame boundary then holds on every lane at the output.

Offset codes are written through a simple write port into a shadow bank. They become active only when a frame pulse is sampled, so a frame already in progress keeps its alignment. A bit-phase counter is restarted by the frame pulse. It drives a strobe that marks the cycle in which the downstream bit sampler should take each bit.

Top module: `skew_align`

## Requirements
- R1: After reset, every lane output and the strobe are 0, and every active offset code is 0.
- R2: With active code c (0 to 8) on a lane, the value that lane_o presents after a rising edge equals lane_i as sampled (10 - c) half clock periods before that edge. An even count refers to a rising-edge sample and an odd count to a falling-edge sample. Code 8 therefore gives the rising-edge sample one cycle earlier, and code 0 gives the value five cycles earlier.
- R3: Each lane uses only its own active code. Lane k is written at cfg_addr = k.
- R4: A code written with a value from 9 to 15 behaves exactly like code 8.
- R5: A write lands in the shadow bank. A frame pulse sampled at rising edge n copies the shadow bank into the active codes, and the first output to use them is the one registered at edge n+1. A write sampled at the same edge as the pulse is not part of that copy.
- R6: Without a frame pulse, writes do not change the active codes, and outputs keep their previous alignment.
- R7: strb_o is 1 exactly when the number of rising edges since the last sampled frame pulse is odd (bit period of 2 cycles, midpoint phase 1). Reset counts as a frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, both edges sample lanes |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse, sampled on rising edge |
| lane_i | input | 4 | Serial input lanes |
| cfg_we | input | 1 | Offset code write enable |
| cfg_addr | input | 2 | Lane number to write |
| cfg_data | input | 4 | Offset code in half clock periods |
| lane_o | output | 4 | Realigned lanes |
| strb_o | output | 1 | Bit midpoint sample indication |

## Verification
The bench sweeps every legal code and several mixed per-lane code sets. An error of one tap would show up as lanes shifted by a half period, with rising and falling samples swapped. Out-of-range codes are written to catch a design that indexes past the tap line instead of clamping. Writes are issued without a pulse, and once on the same edge as a pulse. A design that loads codes at once, or that admits the simultaneous write, would realign in mid-frame. Random frame pulses test whether the strobe restarts its phase at each pulse.

// File: rtl/skew_align_pkg.sv
package skew_align_pkg;
    localparam int CODE_W    = 4;
    localparam int MAX_CODE  = 8;
    localparam int TAP_PAIRS = MAX_CODE / 2 + 1;

    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
        return (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
    endfunction
endpackage

// File: rtl/skew_align_cfg.sv
module skew_align_cfg
    import skew_align_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fp_i,
    input  logic                     we_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [CODE_W-1:0]        data_i,
    output logic [LANES-1:0][CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [LANES-1:0][CODE_W-1:0] shd;
        logic [LANES-1:0][CODE_W-1:0] act;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (fp_i) begin
            for (int i = 0; i < LANES; i++) begin
                cfg_d.act[i] = clamp_code(cfg_q.shd[i]);
            end
        end
        if (we_i && (32'(addr_i) < LANES)) begin
            cfg_d.shd[addr_i] = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign code_o = cfg_q.act;

    // active codes move only on a frame pulse
    assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_i |=> $stable(cfg_q.act));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            fp_i |=> (cfg_q.act[g] <= CODE_W'(MAX_CODE)));
    end
endmodule

// File: rtl/skew_align_tap.sv
module skew_align_tap
    import skew_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              lane_o
);
    typedef struct packed {
        logic [TAP_PAIRS-1:0] r;
        logic [TAP_PAIRS-1:0] f;
        logic                 o;
    } tap_t;

    tap_t tap_d, tap_q;
    logic fall_q;
    logic [CODE_W-1:0] age;

    // falling-edge capture gives the odd half-period taps
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= lane_i;
    end

    always_comb begin
        tap_d   = tap_q;
        tap_d.r = {tap_q.r[TAP_PAIRS-2:0], lane_i};
        tap_d.f = {tap_q.f[TAP_PAIRS-2:0], fall_q};
        age     = CODE_W'(MAX_CODE) - code_i;
        tap_d.o = age[0] ? tap_q.f[age[CODE_W-1:1]] : tap_q.r[age[CODE_W-1:1]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_d;
    end

    assign lane_o = tap_q.o;

    // shortest code path: output is the rising sample one cycle older
    assert_min_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && ($past(code_i) == CODE_W'(MAX_CODE)))
            |-> (tap_q.o == $past(lane_i, 2)));
endmodule

// File: rtl/skew_align_phase.sv
module skew_align_phase #(
    parameter int BIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_i,
    output logic strb_o
);
    localparam int PW  = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam int MID = BIT_CYC / 2;

    typedef struct packed {
        logic [PW-1:0] ph;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (fp_i || (ph_q.ph == PW'(BIT_CYC - 1))) ph_d.ph = '0;
        else                                       ph_d.ph = ph_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign strb_o = (ph_q.ph == PW'(MID));

    assert_fp_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> !strb_o);
    assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_o && !fp_i) |=> !strb_o);
endmodule

// File: rtl/skew_align.sv
module skew_align
    import skew_align_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int AW      = (LANES > 1) ? $clog2(LANES) : 1,
    parameter int BIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_i,
    input  logic [LANES-1:0]  lane_i,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CODE_W-1:0] cfg_data,
    output logic [LANES-1:0]  lane_o,
    output logic              strb_o
);
    logic [LANES-1:0][CODE_W-1:0] code;

    skew_align_cfg #(.LANES(LANES), .AW(AW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .fp_i   (fp_i),
        .we_i   (cfg_we),
        .addr_i (cfg_addr),
        .data_i (cfg_data),
        .code_o (code)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        skew_align_tap u_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .lane_i (lane_i[g]),
            .code_i (code[g]),
            .lane_o (lane_o[g])
        );
    end

    skew_align_phase #(.BIT_CYC(BIT_CYC)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .fp_i   (fp_i),
        .strb_o (strb_o)
    );
endmodule

// File: tb/skew_align_test.sv
module skew_align_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fp_i;
    logic [3:0] lane_i;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [3:0] cfg_data;
    logic [3:0] lane_o;
    logic       strb_o;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    string tag = "R1";

    logic [3:0] rv [0:4095];
    logic [3:0] fv [0:4095];
    logic [3:0] act_m [0:3];
    logic [3:0] shd_m [0:3];
    int ph_m;

    always #5 clk = ~clk;

    skew_align uut (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .lane_i(lane_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .lane_o(lane_o), .strb_o(strb_o)
    );

    function automatic logic [3:0] clampm(input logic [3:0] c);
        return (c > 4'd8) ? 4'd8 : c;
    endfunction

    // value lane l shows after edge e, given code c (from R2)
    function automatic logic expect_bit(input int e, input int l, input logic [3:0] c);
        int a = 8 - int'(c);
        int idx;
        if (a % 2 == 0) begin
            idx = e - 1 - a / 2;
            return (idx < 0) ? 1'b0 : rv[idx][l];
        end
        idx = e - 1 - (a - 1) / 2;
        return (idx < 0) ? 1'b0 : fv[idx][l];
    endfunction

    task automatic chk(input string t, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", t, n, act, exp_v);
        end
    endtask

    task automatic step(input logic f, input logic w, input logic [1:0] a, input logic [3:0] dt);
        logic [3:0] exp_o;
        fp_i = f; cfg_we = w; cfg_addr = a; cfg_data = dt;
        lane_i = 4'($urandom);
        @(negedge clk);
        fv[n + 1] = lane_i;
        #1 lane_i = 4'($urandom);
        @(posedge clk);
        n++;
        rv[n] = lane_i;
        for (int l = 0; l < 4; l++) exp_o[l] = expect_bit(n, l, act_m[l]);
        if (f) for (int l = 0; l < 4; l++) act_m[l] = clampm(shd_m[l]);
        if (w) shd_m[a] = dt;
        ph_m = f ? 0 : (ph_m + 1) % 2;
        #1;
        chk({tag, " lane_o"}, int'(lane_o), int'(exp_o));
        chk("R7 strb_o", int'(strb_o), (ph_m == 1) ? 1 : 0);
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) step(1'b0, 1'b0, 2'd0, 4'd0);
    endtask

    task automatic load4(input logic [3:0] c0, input logic [3:0] c1,
                         input logic [3:0] c2, input logic [3:0] c3);
        step(1'b0, 1'b1, 2'd0, c0);
        step(1'b0, 1'b1, 2'd1, c1);
        step(1'b0, 1'b1, 2'd2, c2);
        step(1'b0, 1'b1, 2'd3, c3);
        step(1'b1, 1'b0, 2'd0, 4'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", n);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D);
        for (int i = 0; i < 4096; i++) begin rv[i] = '0; fv[i] = '0; end
        for (int l = 0; l < 4; l++) begin act_m[l] = '0; shd_m[l] = '0; end
        ph_m = 0;
        rst_n = 1'b0; fp_i = 1'b0; lane_i = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1 lane_o after reset", int'(lane_o), 0);
        chk("R1 strb_o after reset", int'(strb_o), 0);
        tag = "R1";
        idle(20);

        tag = "R2";
        for (int c = 0; c <= 8; c++) begin
            load4(4'(c), 4'(c), 4'(c), 4'(c));
            idle(25);
        end

        tag = "R3";
        load4(4'd1, 4'd4, 4'd7, 4'd2);
        idle(30);
        load4(4'd8, 4'd0, 4'd5, 4'd3);
        idle(30);

        tag = "R4";
        load4(4'd9, 4'd12, 4'd15, 4'd10);
        idle(30);

        tag = "R6";
        step(1'b0, 1'b1, 2'd0, 4'd3);
        step(1'b0, 1'b1, 2'd2, 4'd6);
        idle(20);

        tag = "R5";
        step(1'b1, 1'b1, 2'd1, 4'd2);
        idle(15);
        step(1'b1, 1'b0, 2'd0, 4'd0);
        idle(15);

        tag = "R2";
        for (int i = 0; i < 1200; i++) begin
            step(($urandom % 25) == 0, ($urandom % 5) == 0, 2'($urandom), 4'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule